// File: doc/BRIEF.md
# Real-Time Clock Register Block with Coherent Time Snapshot

This block keeps wall-clock time for a chip. It holds a 32-bit seconds count and a sub-second milliseconds count, both advanced by a strobe from the slow 32.768 kHz timing domain. A parameterised prescaler turns those ticks into millisecond steps. Software reaches the clock through a small synchronous register bus. A single read returns data one cycle after the request.

Software reads the time in two steps. It first reads the milliseconds register, which also freezes the current seconds value into a snapshot register. It then reads the snapshot to get the seconds that belong with those milliseconds, so a rollover between the two reads does no harm. Once every eighth slow tick the block opens a short update window and reports it through a busy flag. Host writes that arrive inside the window are discarded, so software polls the flag before it writes.

The block has two seconds alarms and one milliseconds alarm. Their events collect in a sticky status register that software clears by writing ones. An enable register selects which status bits drive the active-high level interrupt.

Top module: `rtc_regs_top`

## Requirements
- R1: After reset the seconds, milliseconds, snapshot, alarm, enable and status registers all read 0, the busy flag reads 0 and `irqOut` is low.
- R2: The milliseconds count advances once every TICKS_PER_MS tick strobes and counts 0 to MS_PER_SEC-1. The step that follows MS_PER_SEC-1 returns it to 0 and adds one to the seconds count.
- R3: The seconds count wraps from 0xFFFFFFFF to 0.
- R4: A read of the milliseconds register (offset 0x10) copies the seconds value at that read into the snapshot register (offset 0x0C). The snapshot keeps that value until the next milliseconds read, however far the seconds count advances.
- R5: Bit 0 of the busy register (offset 0x04) rises on the tick strobe that completes each group of BUSY_PERIOD ticks counted from reset. It then stays high for BUSY_LEN clock cycles, and no other tick raises it.
- R6: A host write accepted while busy is high has no effect. Reads during busy return data normally.
- R7: A write to the seconds register (offset 0x08) loads the count, and reading it back returns the written value. Alarm registers read back what was written: seconds alarm A at 0x14, seconds alarm B at 0x18, and the milliseconds alarm at 0x1C, which keeps its low bits. An unmapped offset reads 0.
- R8: A seconds alarm holding a nonzero value sets its status bit when the seconds count becomes equal to it: bit 0 for alarm A, bit 1 for alarm B. An alarm that holds 0 never sets its bit.
- R9: A nonzero milliseconds alarm sets status bit 2 when the milliseconds count becomes equal to it.
- R10: Status bits are set whatever the enable register (offset 0x28) holds. `irqOut` is high exactly while some status bit and its enable bit are both 1.
- R11: A write to the status register (offset 0x2C) clears each bit written as 1 and leaves every bit written as 0 unchanged. Writing 0xFFFFFFFF clears every bit.
- R12: The enable register holds five bits, 0 to 4, and its upper bits read 0. Status bits 3 and 4 (countdown events) are never set by this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickStb | input | 1 | One-cycle pulse per 32.768 kHz period |
| selIn | input | 1 | Bus access request |
| wrEnIn | input | 1 | 1 = write, 0 = read |
| addrIn | input | 6 | Byte offset of the register |
| wdataIn | input | 32 | Write data |
| rdataOut | output | 32 | Read data, valid the cycle after a read request |
| irqOut | output | 1 | Active-high level interrupt |

## Verification
The bench builds the block with TICKS_PER_MS=2, MS_PER_SEC=5, BUSY_PERIOD=8 and BUSY_LEN=4. With these values a simulated second lasts only ten ticks. Millisecond rollover, the seconds carry, alarm matches and the wrap of the full 32-bit seconds count after a preload all happen within a few hundred cycles. The short busy window lets the bench issue a read and then a write inside a single window, so it can show that the write is dropped while the read is served.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int EVT_W  = 5;

  localparam logic [ADDR_W-1:0] OFF_BUSY   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_SEC    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_SNAP   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_MS     = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_ALMA   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_ALMB   = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_MSALM  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 6'h28;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 6'h2C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_BUSY, SEL_SEC, SEL_SNAP, SEL_MS,
    SEL_ALMA, SEL_ALMB, SEL_MSALM, SEL_ENABLE, SEL_STATUS
  } regSelE;

  typedef struct packed {
    logic              wrSec;
    logic              wrAlmA;
    logic              wrAlmB;
    logic              wrMsAlm;
    logic              wrEnable;
    logic              clrStatus;
    logic              rdEn;
    logic              rdMs;
    logic              msStep;
    regSelE            rdSel;
    logic [DATA_W-1:0] wdata;
  } rtcStrobeT;

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_MS = 33,
  parameter int BUSY_PERIOD  = 8,
  parameter int BUSY_LEN     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickStb,
  input  logic              selIn,
  input  logic              wrEnIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wdataIn,
  output rtcStrobeT         strb,
  output logic              busyOut
);

  localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam int PH_W  = (BUSY_PERIOD > 1) ? $clog2(BUSY_PERIOD) : 1;
  localparam int LEN_W = $clog2(BUSY_LEN + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(BUSY_PERIOD - 1);

  logic [PRE_W-1:0] preQ;
  logic [PH_W-1:0]  phaseQ;
  logic [LEN_W-1:0] busyCntQ;
  logic             msStep;
  logic             windowOpen;
  regSelE           sel;
  logic             wrOk;

  assign msStep     = tickStb && (preQ == PRE_LAST);
  assign windowOpen = tickStb && (phaseQ == PH_LAST);
  assign busyOut    = (busyCntQ != '0);

  // tick prescaler to millisecond steps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
    end else if (tickStb) begin
      preQ <= (preQ == PRE_LAST) ? '0 : preQ + 1'b1;
    end
  end

  // update-window scheduler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= '0;
      busyCntQ <= '0;
    end else begin
      if (tickStb) begin
        phaseQ <= (phaseQ == PH_LAST) ? '0 : phaseQ + 1'b1;
      end
      if (windowOpen) begin
        busyCntQ <= LEN_W'(BUSY_LEN);
      end else if (busyCntQ != '0) begin
        busyCntQ <= busyCntQ - 1'b1;
      end
    end
  end

  always_comb begin
    unique case (addrIn)
      OFF_BUSY:   sel = SEL_BUSY;
      OFF_SEC:    sel = SEL_SEC;
      OFF_SNAP:   sel = SEL_SNAP;
      OFF_MS:     sel = SEL_MS;
      OFF_ALMA:   sel = SEL_ALMA;
      OFF_ALMB:   sel = SEL_ALMB;
      OFF_MSALM:  sel = SEL_MSALM;
      OFF_ENABLE: sel = SEL_ENABLE;
      OFF_STATUS: sel = SEL_STATUS;
      default:    sel = SEL_NONE;
    endcase
  end

  assign wrOk = selIn && wrEnIn && !busyOut;

  always_comb begin
    strb           = '0;
    strb.wdata     = wdataIn;
    strb.msStep    = msStep;
    strb.rdSel     = sel;
    strb.rdEn      = selIn && !wrEnIn;
    strb.rdMs      = selIn && !wrEnIn && (sel == SEL_MS);
    strb.wrSec     = wrOk && (sel == SEL_SEC);
    strb.wrAlmA    = wrOk && (sel == SEL_ALMA);
    strb.wrAlmB    = wrOk && (sel == SEL_ALMB);
    strb.wrMsAlm   = wrOk && (sel == SEL_MSALM);
    strb.wrEnable  = wrOk && (sel == SEL_ENABLE);
    strb.clrStatus = wrOk && (sel == SEL_STATUS);
  end

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyOut) |-> $past(tickStb)); // R5

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && !tickStb) |=> (busyCntQ == $past(busyCntQ) - 1'b1)); // R5

endmodule

// File: rtl/rtc_dpath.sv
module rtc_dpath
  import rtc_pkg::*;
#(
  parameter int MS_PER_SEC = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobeT         strb,
  input  logic              busyIn,
  output logic [DATA_W-1:0] rdataOut,
  output logic              irqOut
);

  localparam int MS_W = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1;
  localparam int N_SEC_ALM = 2;
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

  logic [DATA_W-1:0] secQ;
  logic [DATA_W-1:0] snapQ;
  logic [MS_W-1:0]   msQ;
  logic [MS_W-1:0]   msAlmQ;
  logic [EVT_W-1:0]  enableQ;
  logic [EVT_W-1:0]  statusQ;
  logic [DATA_W-1:0] secAlmQ [N_SEC_ALM];
  logic [N_SEC_ALM-1:0] secAlmWr;
  logic [N_SEC_ALM-1:0] secMatch;
  logic [N_SEC_ALM-1:0] secMatchPrev;
  logic [N_SEC_ALM-1:0] secHit;
  logic              msMatch;
  logic              msMatchPrev;
  logic              msHit;
  logic              msWrap;
  logic [EVT_W-1:0]  events;
  logic [DATA_W-1:0] rdMux;

  assign msWrap = strb.msStep && (msQ == MS_LAST);

  // time counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msQ  <= '0;
      secQ <= '0;
    end else begin
      if (strb.msStep) begin
        msQ <= msWrap ? '0 : msQ + 1'b1;
      end
      if (strb.wrSec) begin
        secQ <= strb.wdata;
      end else if (msWrap) begin
        secQ <= secQ + 1'b1;
      end
    end
  end

  // snapshot captured on a milliseconds read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapQ <= '0;
    end else if (strb.rdMs) begin
      snapQ <= secQ;
    end
  end

  assign secAlmWr = {strb.wrAlmB, strb.wrAlmA};

  for (genvar g = 0; g < N_SEC_ALM; g++) begin : gSecAlm
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        secAlmQ[g]      <= '0;
        secMatchPrev[g] <= 1'b0;
      end else begin
        if (secAlmWr[g]) begin
          secAlmQ[g] <= strb.wdata;
        end
        secMatchPrev[g] <= secMatch[g];
      end
    end
    assign secMatch[g] = (secAlmQ[g] != '0) && (secQ == secAlmQ[g]);
    assign secHit[g]   = secMatch[g] && !secMatchPrev[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msAlmQ      <= '0;
      msMatchPrev <= 1'b0;
      enableQ     <= '0;
    end else begin
      if (strb.wrMsAlm) begin
        msAlmQ <= strb.wdata[MS_W-1:0];
      end
      if (strb.wrEnable) begin
        enableQ <= strb.wdata[EVT_W-1:0];
      end
      msMatchPrev <= msMatch;
    end
  end

  assign msMatch = (msAlmQ != '0) && (msQ == msAlmQ);
  assign msHit   = msMatch && !msMatchPrev;
  assign events  = {2'b00, msHit, secHit};

  // sticky status, cleared by writing ones; a new event wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ <= (strb.clrStatus ? (statusQ & ~strb.wdata[EVT_W-1:0]) : statusQ)
                 | events;
    end
  end

  assign irqOut = |(statusQ & enableQ);

  always_comb begin
    unique case (strb.rdSel)
      SEL_BUSY:   rdMux = DATA_W'(busyIn);
      SEL_SEC:    rdMux = secQ;
      SEL_SNAP:   rdMux = snapQ;
      SEL_MS:     rdMux = DATA_W'(msQ);
      SEL_ALMA:   rdMux = secAlmQ[0];
      SEL_ALMB:   rdMux = secAlmQ[1];
      SEL_MSALM:  rdMux = DATA_W'(msAlmQ);
      SEL_ENABLE: rdMux = DATA_W'(enableQ);
      SEL_STATUS: rdMux = DATA_W'(statusQ);
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataOut <= '0;
    end else if (strb.rdEn) begin
      rdataOut <= rdMux;
    end
  end

  AST_MS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    msQ <= MS_LAST); // R2

  AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (msWrap && !strb.wrSec) |=> (secQ == $past(secQ) + 1'b1)); // R2

  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!msWrap && !strb.wrSec) |=> $stable(secQ)); // R3

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdMs |=> $stable(snapQ)); // R4

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrStatus |=> (($past(statusQ) & ~statusQ) == '0)); // R11

  AST_NO_COUNTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[4:3] == 2'b00); // R12

endmodule

// File: rtl/rtc_regs_top.sv
module rtc_regs_top
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_MS = 33,
  parameter int MS_PER_SEC   = 1000,
  parameter int BUSY_PERIOD  = 8,
  parameter int BUSY_LEN     = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickStb,
  input  logic        selIn,
  input  logic        wrEnIn,
  input  logic [5:0]  addrIn,
  input  logic [31:0] wdataIn,
  output logic [31:0] rdataOut,
  output logic        irqOut
);

  rtcStrobeT strb;
  logic      busy;

  rtc_ctrl #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .BUSY_PERIOD (BUSY_PERIOD),
    .BUSY_LEN    (BUSY_LEN)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .tickStb(tickStb),
    .selIn  (selIn),
    .wrEnIn (wrEnIn),
    .addrIn (addrIn),
    .wdataIn(wdataIn),
    .strb   (strb),
    .busyOut(busy)
  );

  rtc_dpath #(
    .MS_PER_SEC(MS_PER_SEC)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busyIn  (busy),
    .rdataOut(rdataOut),
    .irqOut  (irqOut)
  );

  AST_BUSY_WRITE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && selIn && wrEnIn && addrIn == OFF_SEC && !strb.msStep)
      |=> $stable(uDpath.secQ)); // R6

endmodule

// File: tb/tb_rtc_regs_top.sv
module tb_rtc_regs_top;

  localparam int TPM = 2;
  localparam int MPS = 5;
  localparam int BP  = 8;
  localparam int BL  = 4;

  localparam logic [5:0] A_BUSY = 6'h04, A_SEC = 6'h08, A_SNAP = 6'h0C,
    A_MS = 6'h10, A_ALMA = 6'h14, A_ALMB = 6'h18, A_MSALM = 6'h1C,
    A_EN = 6'h28, A_ST = 6'h2C;

  logic clk = 0, rstN = 0, tickStb = 0, selIn = 0, wrEnIn = 0;
  logic [5:0]  addrIn = '0;
  logic [31:0] wdataIn = '0;
  logic [31:0] rdataOut;
  logic        irqOut;

  int errors = 0, checks = 0;
  int tickCnt = 0, mdlPre = 0, mdlMs = 0;
  logic [31:0] mdlSec = 0;
  logic [31:0] rd, s0, s1;

  always #5 clk = ~clk;

  rtc_regs_top #(.TICKS_PER_MS(TPM), .MS_PER_SEC(MPS), .BUSY_PERIOD(BP),
                 .BUSY_LEN(BL)) dut (
    .clk(clk), .rstN(rstN), .tickStb(tickStb), .selIn(selIn),
    .wrEnIn(wrEnIn), .addrIn(addrIn), .wdataIn(wdataIn),
    .rdataOut(rdataOut), .irqOut(irqOut));

  // {isWrite, addr, data, expected}
  localparam int NV = 16;
  localparam logic [70:0] VEC [NV] = '{
    {1'b1, 6'h08, 32'h1234_5678, 32'h0},
    {1'b0, 6'h08, 32'h0,         32'h1234_5678},
    {1'b1, 6'h14, 32'h55,        32'h0},
    {1'b0, 6'h14, 32'h0,         32'h55},
    {1'b1, 6'h18, 32'hA0,        32'h0},
    {1'b0, 6'h18, 32'h0,         32'hA0},
    {1'b1, 6'h1C, 32'h3,         32'h0},
    {1'b0, 6'h1C, 32'h0,         32'h3},
    {1'b1, 6'h1C, 32'h0,         32'h0},
    {1'b1, 6'h28, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 6'h28, 32'h0,         32'h1F},
    {1'b1, 6'h28, 32'h0,         32'h0},
    {1'b1, 6'h14, 32'h0,         32'h0},
    {1'b1, 6'h18, 32'h0,         32'h0},
    {1'b0, 6'h20, 32'h0,         32'h0},
    {1'b1, 6'h2C, 32'hFFFF_FFFF, 32'h0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    selIn = 1; wrEnIn = 1; addrIn = a; wdataIn = d;
    @(negedge clk);
    selIn = 0; wrEnIn = 0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    selIn = 1; wrEnIn = 0; addrIn = a;
    @(negedge clk);
    d = rdataOut;
    selIn = 0;
  endtask

  task automatic modelTick();
    tickCnt++;
    if (mdlPre == TPM - 1) begin
      mdlPre = 0;
      if (mdlMs == MPS - 1) begin
        mdlMs = 0;
        mdlSec = mdlSec + 1;
      end else mdlMs++;
    end else mdlPre++;
  endtask

  task automatic rawTick();
    @(negedge clk) tickStb = 1;
    @(negedge clk) tickStb = 0;
    modelTick();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      rawTick();
      repeat (BL + 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    busRead(A_SEC, rd);   check("R1 seconds", rd, 32'h0);
    busRead(A_MS, rd);    check("R1 millis", rd, 32'h0);
    busRead(A_SNAP, rd);  check("R1 snapshot", rd, 32'h0);
    busRead(A_ALMA, rd);  check("R1 alarmA", rd, 32'h0);
    busRead(A_EN, rd);    check("R1 enable", rd, 32'h0);
    busRead(A_ST, rd);    check("R1 status", rd, 32'h0);
    busRead(A_BUSY, rd);  check("R1 busy", rd, 32'h0);

    // register table: R7 readback, R12 enable width, unmapped read
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][70]) busWrite(VEC[v][69:64], VEC[v][63:32]);
      else begin
        busRead(VEC[v][69:64], rd);
        check("R7/R12 table", rd, VEC[v][31:0]);
      end
    end
    mdlSec = 32'h1234_5678;

    // R2 millisecond stepping and seconds carry
    for (int i = 0; i < 14; i++) begin
      ticks(1);
      busRead(A_MS, rd);  check("R2 millis", rd, 32'(mdlMs));
      busRead(A_SEC, rd); check("R2 seconds", rd, mdlSec);
    end

    // R4 snapshot coherence
    busRead(A_MS, rd); check("R4 millis read", rd, 32'(mdlMs));
    s0 = mdlSec;
    while (mdlSec == s0) ticks(1);
    busRead(A_SNAP, rd); check("R4 snapshot held", rd, s0);
    busRead(A_SEC, rd);  check("R4 seconds moved", rd, mdlSec);
    busRead(A_MS, rd);
    busRead(A_SNAP, rd); check("R4 snapshot refreshed", rd, mdlSec);

    // R5/R6 busy window
    while (tickCnt % BP != BP - 2) ticks(1);
    rawTick();
    busRead(A_BUSY, rd); check("R5 busy off between windows", rd, 32'h0);
    repeat (BL + 1) @(negedge clk);
    rawTick();
    busRead(A_BUSY, rd); check("R5/R6 busy read during window", rd, 32'h1);
    busWrite(A_SEC, 32'hDEAD_BEEF);
    busRead(A_BUSY, rd); check("R5 busy closed after BUSY_LEN", rd, 32'h0);
    busRead(A_SEC, rd);  check("R6 write dropped", rd, mdlSec);
    busWrite(A_SEC, 32'h0000_0100); mdlSec = 32'h100;
    busRead(A_SEC, rd);  check("R7 write after window", rd, 32'h100);

    // R8/R10/R11 seconds alarms
    s1 = mdlSec;
    busWrite(A_ALMA, s1 + 2);
    busWrite(A_ALMB, s1 + 3);
    while (mdlSec != s1 + 2) ticks(1);
    busRead(A_ST, rd); check("R8 alarmA status", rd, 32'h1);
    check("R10 masked irq low", {31'b0, irqOut}, 32'h0);
    busWrite(A_EN, 32'h1);
    check("R10 irq high", {31'b0, irqOut}, 32'h1);
    busWrite(A_ST, 32'h0);
    busRead(A_ST, rd); check("R11 zero write keeps", rd, 32'h1);
    busWrite(A_ST, 32'h1);
    busRead(A_ST, rd); check("R11 one write clears", rd, 32'h0);
    check("R10 irq low after clear", {31'b0, irqOut}, 32'h0);
    while (mdlSec != s1 + 3) ticks(1);
    busRead(A_ST, rd); check("R8 alarmB status", rd, 32'h2);
    check("R10 other bit not enabled", {31'b0, irqOut}, 32'h0);
    busWrite(A_ST, 32'hFFFF_FFFF);

    // R9 milliseconds alarm
    busWrite(A_MSALM, 32'h3);
    while (mdlMs != 3) ticks(1);
    busRead(A_ST, rd); check("R9 ms alarm status", rd, 32'h4);
    busWrite(A_MSALM, 32'h0);
    busWrite(A_ST, 32'hFFFF_FFFF);
    busRead(A_ST, rd); check("R11 clear all", rd, 32'h0);

    // R3 wrap, R8 zero alarm silent
    busWrite(A_ALMA, 32'h0);
    busWrite(A_ALMB, 32'h0);
    busWrite(A_SEC, 32'hFFFF_FFFF); mdlSec = 32'hFFFF_FFFF;
    while (mdlSec != 32'h0) ticks(1);
    busRead(A_SEC, rd); check("R3 seconds wrap", rd, 32'h0);
    ticks(2);
    busRead(A_ST, rd); check("R8 zero alarm silent", rd, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule